// File: doc/BRIEF.md
# Stack-Relative Data Cache

This block is a small direct-mapped data cache placed beside a processor core that serves only accesses the core marks as stack or frame relative. Every request carries a stack flag, a word address and a read/write command. A stack read whose word is resident is answered one cycle after acceptance. A stack read that misses is answered from main memory. The memory read starts only once the lookup has shown the miss, never alongside the lookup. Reads without the stack flag always go to main memory and never allocate a line.

Writes never stall for memory. Each accepted write is handed one cycle later to an external write queue. A stack write also places its data in the cache line straight away, whether that line held the address or not, so a write miss allocates without any fetch. Because the lines are indexed by the low bits of the word address, the sixteen consecutive words above a frame base occupy sixteen distinct lines. Once written or loaded, they stay resident until a conflicting address evicts them.

Top module: `stack_dcache`

## Requirements
- R1: A read with `req_stack` low always raises `mem_rd_req` one cycle after acceptance, returns the memory word, and leaves the cache contents unchanged, so a repeat of it misses again.
- R2: A write with `req_stack` low is pushed to the write queue and does not alter any cache line; a later stack read of the same address still returns the earlier cached data.
- R3: A stack read that hits gives `rsp_valid` high with the line data in the cycle after acceptance, and `mem_rd_req` stays low.
- R4: On a read miss, `mem_rd_req` is low in the acceptance cycle and rises in the next cycle with `mem_rd_addr` equal to the request address; `req_ready` stays low and `mem_rd_req` stays high until `mem_rd_resp_valid`.
- R5: One cycle after `mem_rd_resp_valid`, `rsp_valid` is high with the returned word, `mem_rd_req` is low and `req_ready` is high; for a stack read the word is filled so the next read of that address hits.
- R6: Every accepted write raises `wq_valid` for one cycle in the next cycle with the request address and data; a stack write stores the data in its line without any memory read, and writes give no `rsp_valid`.
- R7: A stack read accepted in the cycle right after a stack write to the same address hits and returns the written data.
- R8: The line index is address bits [log2(DEPTH)-1:0] and the tag is the remaining upper bits; a stack access to another address with the same index evicts the resident word.
- R9: Synchronous reset `rst` clears every valid bit and leaves `req_ready` high with `rsp_valid`, `wq_valid` and `mem_rd_req` low; the first stack read after reset misses.
- R10: After the sixteen words at offsets 0 to 15 above a frame base are written, reading all sixteen back hits with no memory request (DEPTH is a power of two of at least 16; 64 by default, 128 supported).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_stack | input | 1 | Request is stack or frame relative |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW | Read data |
| mem_rd_req | output | 1 | Main-memory read request, held until response |
| mem_rd_addr | output | AW | Main-memory read address |
| mem_rd_resp_valid | input | 1 | Main-memory read data valid |
| mem_rd_resp_data | input | DW | Main-memory read data |
| wq_valid | output | 1 | Write-queue push |
| wq_addr | output | AW | Write-queue address |
| wq_data | output | DW | Write-queue data |

## Verification
Two functions can share a cycle. The write-queue push of a stack write and the lookup of the read accepted straight after it fall in the same cycle, and the read must already see the word the write put in the line. The bench issues such pairs to the same address with no idle cycle between them. In that one cycle it checks the queued address and data, and in the next cycle it checks that the read hits with the written value and raises no memory request. Random mixes of stack and plain accesses around a few conflicting frame bases, with memory latencies of zero to four cycles, are compared against a bench model of the valid bits, tags and data.

// File: rtl/stkc_pkg.sv
package stkc_pkg;
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_FETCH = 1'b1
    } phase_e;
endpackage

// File: rtl/stkc_line_store.sv
module stkc_line_store #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int IDXW = $clog2(DEPTH),
    localparam int TAGW = AW - IDXW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IDXW-1:0] rd_idx,
    output logic            rd_valid,
    output logic [TAGW-1:0] rd_tag,
    output logic [DW-1:0]   rd_data,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [TAGW-1:0] wr_tag,
    input  logic [DW-1:0]   wr_data
);
    logic [DEPTH-1:0] valid_d, valid_q;
    logic [TAGW-1:0]  tag_q  [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= '0;
        else     valid_q <= valid_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDXW'(g)) begin
                tag_q[g]  <= wr_tag;
                data_q[g] <= wr_data;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    // R9: the cycle after reset, no line is valid
    assert_reset_clears_R9: assert property (@(posedge clk)
        $past(rst) |-> (valid_q == '0));

    // R8: a write leaves its line valid with the new tag
    assert_fill_lands_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
                   && data_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/stkc_ctrl.sv
module stkc_ctrl
    import stkc_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int IDXW = $clog2(DEPTH),
    localparam int TAGW = AW - IDXW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_stack,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            req_ready,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_rdata,
    output logic            mem_rd_req,
    output logic [AW-1:0]   mem_rd_addr,
    input  logic            mem_rd_resp_valid,
    input  logic [DW-1:0]   mem_rd_resp_data,
    output logic            wq_valid,
    output logic [AW-1:0]   wq_addr,
    output logic [DW-1:0]   wq_data,
    output logic [IDXW-1:0] lk_idx,
    input  logic            lk_valid,
    input  logic [TAGW-1:0] lk_tag,
    input  logic [DW-1:0]   lk_data,
    output logic            st_wr_en,
    output logic [IDXW-1:0] st_wr_idx,
    output logic [TAGW-1:0] st_wr_tag,
    output logic [DW-1:0]   st_wr_data
);
    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] addr;
        logic          fill;
        logic          rsp_valid;
        logic [DW-1:0] rsp_data;
        logic          wq_valid;
        logic [AW-1:0] wq_addr;
        logic [DW-1:0] wq_data;
        logic          mem_req;
    } state_t;

    state_t s_d, s_q;
    logic   accept, lk_hit;

    assign lk_idx = req_addr[IDXW-1:0];
    assign lk_hit = req_stack && lk_valid && (lk_tag == req_addr[AW-1:IDXW]);
    assign accept = req_valid && (s_q.phase == PH_IDLE);

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        s_d.wq_valid  = 1'b0;
        st_wr_en      = 1'b0;
        st_wr_idx     = req_addr[IDXW-1:0];
        st_wr_tag     = req_addr[AW-1:IDXW];
        st_wr_data    = req_wdata;
        if (s_q.phase == PH_IDLE) begin
            if (accept) begin
                if (req_write) begin
                    s_d.wq_valid = 1'b1;
                    s_d.wq_addr  = req_addr;
                    s_d.wq_data  = req_wdata;
                    st_wr_en     = req_stack;
                end else if (lk_hit) begin
                    s_d.rsp_valid = 1'b1;
                    s_d.rsp_data  = lk_data;
                end else begin
                    s_d.phase   = PH_FETCH;
                    s_d.addr    = req_addr;
                    s_d.fill    = req_stack;
                    s_d.mem_req = 1'b1;
                end
            end
        end else begin
            st_wr_idx  = s_q.addr[IDXW-1:0];
            st_wr_tag  = s_q.addr[AW-1:IDXW];
            st_wr_data = mem_rd_resp_data;
            if (mem_rd_resp_valid) begin
                s_d.phase     = PH_IDLE;
                s_d.mem_req   = 1'b0;
                s_d.rsp_valid = 1'b1;
                s_d.rsp_data  = mem_rd_resp_data;
                st_wr_en      = s_q.fill;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign req_ready   = (s_q.phase == PH_IDLE);
    assign rsp_valid   = s_q.rsp_valid;
    assign rsp_rdata   = s_q.rsp_data;
    assign mem_rd_req  = s_q.mem_req;
    assign mem_rd_addr = s_q.addr;
    assign wq_valid    = s_q.wq_valid;
    assign wq_addr     = s_q.wq_addr;
    assign wq_data     = s_q.wq_data;

    // R4: memory read starts only in the cycle after a read lookup that missed
    assert_fetch_after_miss_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd_req) |-> $past(req_valid && req_ready && !req_write && !lk_hit));

    // R4: requests are held off while memory is outstanding
    assert_stall_during_fetch_R4: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> !req_ready);

    // R3: a hit answers next cycle without touching memory
    assert_hit_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write && lk_hit) |=> (rsp_valid && !mem_rd_req
                                              && rsp_rdata == $past(lk_data)));

    // R6: each write is queued one cycle later
    assert_write_queued_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write) |=> (wq_valid && wq_addr == $past(req_addr)
                                   && wq_data == $past(req_wdata) && !rsp_valid));

    // R5: memory data is returned the cycle after it arrives
    assert_resp_forward_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_resp_valid) |=> (rsp_valid && req_ready && !mem_rd_req
                                               && rsp_rdata == $past(mem_rd_resp_data)));
endmodule

// File: rtl/stack_dcache.sv
module stack_dcache #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_stack,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_resp_valid,
    input  logic [DW-1:0] mem_rd_resp_data,
    output logic          wq_valid,
    output logic [AW-1:0] wq_addr,
    output logic [DW-1:0] wq_data
);
    localparam int IDXW = $clog2(DEPTH);
    localparam int TAGW = AW - IDXW;

    logic [IDXW-1:0] lk_idx, st_wr_idx;
    logic            lk_valid, st_wr_en;
    logic [TAGW-1:0] lk_tag, st_wr_tag;
    logic [DW-1:0]   lk_data, st_wr_data;

    stkc_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_ctrl (
        .clk               (clk),
        .rst               (rst),
        .req_valid         (req_valid),
        .req_stack         (req_stack),
        .req_write         (req_write),
        .req_addr          (req_addr),
        .req_wdata         (req_wdata),
        .req_ready         (req_ready),
        .rsp_valid         (rsp_valid),
        .rsp_rdata         (rsp_rdata),
        .mem_rd_req        (mem_rd_req),
        .mem_rd_addr       (mem_rd_addr),
        .mem_rd_resp_valid (mem_rd_resp_valid),
        .mem_rd_resp_data  (mem_rd_resp_data),
        .wq_valid          (wq_valid),
        .wq_addr           (wq_addr),
        .wq_data           (wq_data),
        .lk_idx            (lk_idx),
        .lk_valid          (lk_valid),
        .lk_tag            (lk_tag),
        .lk_data           (lk_data),
        .st_wr_en          (st_wr_en),
        .st_wr_idx         (st_wr_idx),
        .st_wr_tag         (st_wr_tag),
        .st_wr_data        (st_wr_data)
    );

    stkc_line_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_valid (lk_valid),
        .rd_tag   (lk_tag),
        .rd_data  (lk_data),
        .wr_en    (st_wr_en),
        .wr_idx   (st_wr_idx),
        .wr_tag   (st_wr_tag),
        .wr_data  (st_wr_data)
    );
endmodule

// File: tb/tb_stack_dcache.sv
module tb_stack_dcache;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int DEPTH = 64;
    localparam int IDXW  = $clog2(DEPTH);
    localparam int TAGW  = AW - IDXW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_stack = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_rd_req, wq_valid;
    logic [DW-1:0] rsp_rdata, wq_data;
    logic [AW-1:0] mem_rd_addr, wq_addr;
    logic mem_rd_resp_valid = 1'b0;
    logic [DW-1:0] mem_rd_resp_data = '0;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 1'b0;

    logic            m_val [DEPTH];
    logic [TAGW-1:0] m_tag [DEPTH];
    logic [DW-1:0]   m_dat [DEPTH];

    always #2 clk = ~clk;

    stack_dcache #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (.*);

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return {a, ~a} ^ 32'h5A5A_0000;
    endfunction

    function automatic bit predict_hit(input bit stk, input logic [AW-1:0] a);
        return stk && m_val[a[IDXW-1:0]] && m_tag[a[IDXW-1:0]] == a[AW-1:IDXW];
    endfunction

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < DEPTH; i++) m_val[i] = 1'b0;
    endtask

    // Called at a negedge; returns at a negedge with the request retired.
    task automatic access(input bit stk, input bit wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input string lbl);
        bit hit;
        int lat;
        logic [IDXW-1:0] ix;
        string r;
        ix  = a[IDXW-1:0];
        hit = !wr && predict_hit(stk, a);
        chk(req_ready == 1'b1, "R4 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_stack = stk; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) begin
            r = (lbl != "") ? lbl : (stk ? "R6 stack write" : "R2 plain write");
            chk(wq_valid == 1'b1, r, 32'(wq_valid), 32'd1);
            chk(wq_addr == a && wq_data == d, r, wq_data, d);
            chk(rsp_valid == 1'b0 && mem_rd_req == 1'b0, r, 32'({rsp_valid, mem_rd_req}), 32'd0);
            if (stk) begin
                m_val[ix] = 1'b1; m_tag[ix] = a[AW-1:IDXW]; m_dat[ix] = d;
            end
        end else if (hit) begin
            r = (lbl != "") ? lbl : "R3 stack hit";
            chk(rsp_valid == 1'b1 && mem_rd_req == 1'b0, r, 32'({rsp_valid, mem_rd_req}), 32'b10);
            chk(rsp_rdata == m_dat[ix], r, rsp_rdata, m_dat[ix]);
        end else begin
            r = (lbl != "") ? lbl : (stk ? "R4 stack miss" : "R1 plain read");
            chk(mem_rd_req == 1'b1 && mem_rd_addr == a && req_ready == 1'b0 && rsp_valid == 1'b0,
                r, 32'(mem_rd_addr), 32'(a));
            lat = $urandom_range(0, 4);
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                chk(mem_rd_req == 1'b1 && req_ready == 1'b0, "R4 stall held",
                    32'({mem_rd_req, req_ready}), 32'b10);
            end
            mem_rd_resp_valid = 1'b1; mem_rd_resp_data = memf(a);
            @(negedge clk);
            mem_rd_resp_valid = 1'b0;
            chk(rsp_valid == 1'b1 && rsp_rdata == memf(a), "R5 fill data", rsp_rdata, memf(a));
            chk(mem_rd_req == 1'b0 && req_ready == 1'b1, "R5 fetch ends",
                32'({mem_rd_req, req_ready}), 32'b01);
            if (stk) begin
                m_val[ix] = 1'b1; m_tag[ix] = a[AW-1:IDXW]; m_dat[ix] = memf(a);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_model();
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && wq_valid == 1'b0 && mem_rd_req == 1'b0,
            "R9 reset outputs", 32'({req_ready, rsp_valid, wq_valid, mem_rd_req}), 32'b1000);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] bases [3];
        logic [DW-1:0] d1;
        void'($urandom(32'd2024));
        bases[0] = 16'h0100; bases[1] = 16'h0140; bases[2] = 16'h2030;
        do_reset();

        // R1: plain reads always go to memory, never allocate
        access(1'b0, 1'b0, 16'h0500, '0, "R1 plain read first");
        access(1'b0, 1'b0, 16'h0500, '0, "R1 plain read repeat");
        access(1'b1, 1'b0, 16'h0500, '0, "R1 no allocation");

        // R2: plain write does not disturb the cached word
        d1 = 32'hCAFE_0001;
        access(1'b1, 1'b1, 16'h0207, d1, "");
        access(1'b0, 1'b1, 16'h0207, 32'h1111_2222, "R2 plain write queued");
        access(1'b1, 1'b0, 16'h0207, '0, "R2 cached word kept");
        chk(rsp_rdata == d1, "R2 cached word kept", rsp_rdata, d1);

        // R7: write then immediate read, same address, no idle cycle
        access(1'b1, 1'b1, 16'h0311, 32'hBEEF_0007, "R7 write push");
        access(1'b1, 1'b0, 16'h0311, '0, "R7 read after write");

        // R6: write miss allocates without fetch; R8 eviction by same index
        access(1'b1, 1'b1, 16'h0105, 32'hAAAA_5555, "R6 write allocate");
        access(1'b1, 1'b0, 16'h0105, '0, "R6 allocated hit");
        access(1'b1, 1'b0, 16'h0145, '0, "R8 conflict miss");
        access(1'b1, 1'b0, 16'h0105, '0, "R8 evicted miss");
        chk(rsp_rdata == memf(16'h0105), "R8 evicted data", rsp_rdata, memf(16'h0105));

        // R10: sixteen frame words written then all hit
        for (int i = 0; i < 16; i++)
            access(1'b1, 1'b1, AW'(16'h03A0 + i), 32'h7000_0000 + 32'(i), "R10 frame write");
        for (int i = 0; i < 16; i++) begin
            chk(predict_hit(1'b1, AW'(16'h03A0 + i)), "R10 model hit", 32'(i), 32'(i));
            access(1'b1, 1'b0, AW'(16'h03A0 + i), '0, "R10 frame hit");
        end

        // R5: filled word hits next time
        access(1'b1, 1'b0, 16'h0777, '0, "R5 miss fill");
        access(1'b1, 1'b0, 16'h0777, '0, "R5 refill hit");

        // Random mix around conflicting bases
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            a = bases[$urandom_range(0, 2)] + AW'($urandom_range(0, 15));
            access($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, a, $urandom, "");
        end

        // R9: reset drops residency
        access(1'b1, 1'b1, 16'h0102, 32'h0BAD_F00D, "");
        do_reset();
        access(1'b1, 1'b0, 16'h0102, '0, "R9 miss after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule